// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between the memory stage of a core and a data memory that is 32 bits wide and addressed by word. For every access it forms the effective address from a base register and a signed 16-bit displacement. It checks that the address suits the access size. For an aligned access it drives byte-lane enables and store data already steered into the right lanes. An access that breaks the alignment rule is stopped before it reaches memory. Instead the unit raises an address-error exception, with a cause code that tells a load apart from a store, and passes the faulting address on for the bad-address register.

The unit handles both byte numberings. In little-endian mode, byte 0 of a word sits in the least significant lane. In big-endian mode, byte 0 sits in the most significant lane. Everything on the request side is combinational. One register stage records the size, the extension mode and the lane of an accepted load. In the next cycle the unit picks the addressed bytes out of the word that memory returns and sign- or zero-extends them.

Top module: `lsu_lane_unit`

## Requirements
- R1: `addr_o` equals `base_i` plus `offset_i` sign-extended to 32 bits, modulo 2^32, whenever `req_valid_i` is high, faulting or not.
- R2: `size_i` encodes 0 = byte, 1 = halfword, 2 = word, and 3 is treated as a word. A halfword faults when address bit 0 is set. A word faults when address bits 1:0 are nonzero. A byte never faults.
- R3: On a fault, `fault_o` is high, `exc_code_o` is 4 for a load and 5 for a store, and `bad_addr_o` equals the effective address. Without a fault, all three read zero.
- R4: When there is a fault or no valid request, `be_o` is 0000 and `mem_req_o` is low. Otherwise `mem_req_o` is high.
- R5: `wdata_o` carries the low byte of `wdata_i` copied into all four lanes for a byte access, the low halfword copied into both halves for a halfword access, and `wdata_i` unchanged for a word access.
- R6: `be_o` bit i enables data bits 8i+7:8i. In little-endian mode (`big_endian_i` = 0), a byte at address offset a enables bit a, a halfword enables bits a and a+1, and a word enables all four bits.
- R7: In big-endian mode, a byte at address offset a enables bit 3-a. A halfword at offset 0 enables 1100, a halfword at offset 2 enables 0011, and a word enables 1111.
- R8: `load_valid_o` is high in the cycle after a valid, non-faulting load request and low otherwise. In that cycle `load_data_o` is formed combinationally from `rdata_i`. At all other times it is zero.
- R9: A byte or halfword load sign-extends when `unsigned_i` was 0 and zero-extends when it was 1. A word load returns all 32 bits.
- R10: Load bytes are taken from the lanes that R6 and R7 name for the size, address and endianness recorded at request time. A multi-byte value places the lowest-addressed byte as the least significant byte in little-endian mode and as the most significant byte in big-endian mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request this cycle |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed displacement |
| size_i | input | 2 | Access size code |
| unsigned_i | input | 1 | Zero-extend load data |
| store_i | input | 1 | 1 = store, 0 = load |
| big_endian_i | input | 1 | Byte numbering select |
| wdata_i | input | 32 | Store source register |
| rdata_i | input | 32 | Word returned by memory |
| addr_o | output | 32 | Effective address |
| be_o | output | 4 | Byte-lane enables |
| wdata_o | output | 32 | Lane-steered store data |
| mem_req_o | output | 1 | Access sent to memory |
| fault_o | output | 1 | Alignment fault |
| exc_code_o | output | 5 | Exception cause code |
| bad_addr_o | output | 32 | Faulting address |
| load_valid_o | output | 1 | Aligned load data valid |
| load_data_o | output | 32 | Extracted and extended load data |

## Verification
The embedded assertions check rules that hold on every cycle. A fault never comes with byte enables, and each cause code matches the request direction. A byte access enables exactly one lane, and an issued word access is always word-aligned. Load-valid follows only an accepted load, and a zero-extended byte load keeps its upper bits clear. The exact lane for each size, offset and endianness, the value of replicated store data, and the sign or zero extension of bytes taken from particular lanes depend on the data. Only the bench's reference functions can show these, using random and directed scenarios.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  localparam int unsigned EXC_W = 5;
  localparam logic [EXC_W-1:0] EXC_ADDR_LOAD  = 5'd4;
  localparam logic [EXC_W-1:0] EXC_ADDR_STORE = 5'd5;

  // lowest lane touched by an access
  function automatic logic [1:0] lane_base(input logic [1:0] sz, input logic [1:0] a,
                                           input logic big);
    logic [1:0] span;
    span = (sz == SZ_BYTE) ? 2'd0 : (sz == SZ_HALF) ? 2'd1 : 2'd3;
    return big ? 2'(2'd3 - span - a) : a;
  endfunction
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
  parameter int unsigned AW   = 32,
  parameter int unsigned OFFW = 16
) (
  input  logic [AW-1:0]   base_i,
  input  logic [OFFW-1:0] offset_i,
  input  logic [1:0]      size_i,
  input  logic            valid_i,
  input  logic            store_i,
  output logic [AW-1:0]   ea_o,
  output logic            fault_o,
  output logic [lsu_pkg::EXC_W-1:0] code_o,
  output logic [AW-1:0]   bad_addr_o
);
  import lsu_pkg::*;
  localparam int unsigned EXTW = AW - OFFW;

  logic misalign;

  assign ea_o = base_i + {{EXTW{offset_i[OFFW-1]}}, offset_i};

  always_comb begin
    unique case (size_i)
      SZ_BYTE: misalign = 1'b0;
      SZ_HALF: misalign = ea_o[0];
      default: misalign = |ea_o[1:0];
    endcase
  end

  assign fault_o    = valid_i & misalign;
  assign code_o     = !fault_o ? '0 : (store_i ? EXC_ADDR_STORE : EXC_ADDR_LOAD);
  assign bad_addr_o = fault_o ? ea_o : '0;
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes #(
  parameter int unsigned DW = 32
) (
  input  logic          en_i,
  input  logic [1:0]    size_i,
  input  logic [1:0]    lane_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW/8-1:0] be_o,
  output logic [DW-1:0] wdata_o
);
  import lsu_pkg::*;
  localparam int unsigned NB = DW / 8;

  logic [NB-1:0] mask;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: mask = NB'(1);
      SZ_HALF: mask = NB'(3);
      default: mask = '1;
    endcase
  end

  assign be_o = en_i ? NB'(mask << lane_i) : '0;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    always_comb begin
      unique case (size_i)
        SZ_BYTE: wdata_o[8*i +: 8] = wdata_i[7:0];
        SZ_HALF: wdata_o[8*i +: 8] = wdata_i[8*(i%2) +: 8];
        default: wdata_o[8*i +: 8] = wdata_i[8*i +: 8];
      endcase
    end
  end
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          capture_i,
  input  logic [1:0]    size_i,
  input  logic          unsigned_i,
  input  logic [1:0]    lane_i,
  input  logic [DW-1:0] rdata_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o
);
  import lsu_pkg::*;

  logic          vld_q, uns_q;
  logic [1:0]    size_q, lane_q;
  logic [DW-1:0] shifted;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      uns_q  <= 1'b0;
      size_q <= 2'd0;
      lane_q <= 2'd0;
    end else begin
      vld_q <= capture_i;
      if (capture_i) begin
        uns_q  <= unsigned_i;
        size_q <= size_i;
        lane_q <= lane_i;
      end
    end
  end

  assign shifted = rdata_i >> {lane_q, 3'b000};

  always_comb begin
    data_o = '0;
    if (vld_q) begin
      unique case (size_q)
        SZ_BYTE: data_o = {{(DW-8){~uns_q & shifted[7]}}, shifted[7:0]};
        SZ_HALF: data_o = {{(DW-16){~uns_q & shifted[15]}}, shifted[15:0]};
        default: data_o = shifted;
      endcase
    end
  end

  assign valid_o = vld_q;

  AST_ZEXT_BYTE_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_i && unsigned_i && size_i == SZ_BYTE) |=> (data_o[DW-1:8] == '0)); // R9
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit #(
  parameter int unsigned AW   = 32,
  parameter int unsigned OFFW = 16,
  parameter int unsigned DW   = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [AW-1:0]   base_i,
  input  logic [OFFW-1:0] offset_i,
  input  logic [1:0]      size_i,
  input  logic            unsigned_i,
  input  logic            store_i,
  input  logic            big_endian_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW-1:0]   rdata_i,
  output logic [AW-1:0]   addr_o,
  output logic [DW/8-1:0] be_o,
  output logic [DW-1:0]   wdata_o,
  output logic            mem_req_o,
  output logic            fault_o,
  output logic [4:0]      exc_code_o,
  output logic [AW-1:0]   bad_addr_o,
  output logic            load_valid_o,
  output logic [DW-1:0]   load_data_o
);
  import lsu_pkg::*;

  logic [1:0] lane;

  lsu_addr_gen #(.AW(AW), .OFFW(OFFW)) u_addr (
    .base_i    (base_i),
    .offset_i  (offset_i),
    .size_i    (size_i),
    .valid_i   (req_valid_i),
    .store_i   (store_i),
    .ea_o      (addr_o),
    .fault_o   (fault_o),
    .code_o    (exc_code_o),
    .bad_addr_o(bad_addr_o)
  );

  assign mem_req_o = req_valid_i & ~fault_o;
  assign lane      = lane_base(size_i, addr_o[1:0], big_endian_i);

  lsu_store_lanes #(.DW(DW)) u_store (
    .en_i   (mem_req_o),
    .size_i (size_i),
    .lane_i (lane),
    .wdata_i(wdata_i),
    .be_o   (be_o),
    .wdata_o(wdata_o)
  );

  lsu_load_align #(.DW(DW)) u_load (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (mem_req_o & ~store_i),
    .size_i    (size_i),
    .unsigned_i(unsigned_i),
    .lane_i    (lane),
    .rdata_i   (rdata_i),
    .valid_o   (load_valid_o),
    .data_o    (load_data_o)
  );

  AST_FAULT_NO_BE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (be_o == '0 && !mem_req_o)); // R4
  AST_STORE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && store_i) |-> (exc_code_o == EXC_ADDR_STORE)); // R3
  AST_LOAD_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !store_i) |-> (exc_code_o == EXC_ADDR_LOAD)); // R3
  AST_BYTE_ONE_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && size_i == SZ_BYTE) |-> ($countones(be_o) == 1)); // R6
  AST_WORD_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && size_i[1]) |-> (addr_o[1:0] == 2'b00)); // R2
  AST_LOAD_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !store_i && !fault_o) |=> load_valid_o); // R8
  AST_NO_SPURIOUS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i || store_i || fault_o) |=> !load_valid_o); // R8
endmodule

// File: tb/lsu_lane_unit_test.sv
module lsu_lane_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] offset_i = '0;
  logic [1:0]  size_i = '0;
  logic        unsigned_i = 1'b0;
  logic        store_i = 1'b0;
  logic        big_endian_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_i = '0;
  logic [31:0] addr_o, wdata_o, bad_addr_o, load_data_o;
  logic [3:0]  be_o;
  logic        mem_req_o, fault_o, load_valid_o;
  logic [4:0]  exc_code_o;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  lsu_lane_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .base_i(base_i),
    .offset_i(offset_i), .size_i(size_i), .unsigned_i(unsigned_i), .store_i(store_i),
    .big_endian_i(big_endian_i), .wdata_i(wdata_i), .rdata_i(rdata_i), .addr_o(addr_o),
    .be_o(be_o), .wdata_o(wdata_o), .mem_req_o(mem_req_o), .fault_o(fault_o),
    .exc_code_o(exc_code_o), .bad_addr_o(bad_addr_o), .load_valid_o(load_valid_o),
    .load_data_o(load_data_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic int lane_of(input int byte_addr, input bit big);
    return big ? 3 - byte_addr : byte_addr;
  endfunction

  function automatic bit is_fault(input logic [1:0] sz, input logic [31:0] ea);
    return (nbytes(sz) == 2 && ea[0]) || (nbytes(sz) == 4 && ea[1:0] != 0);
  endfunction

  function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] a, input bit big);
    logic [3:0] m = '0;
    for (int k = 0; k < nbytes(sz); k++) m[lane_of(int'(a) + k, big)] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] exp_wd(input logic [1:0] sz, input logic [31:0] w);
    if (sz == 2'd0) return {4{w[7:0]}};
    if (sz == 2'd1) return {2{w[15:0]}};
    return w;
  endfunction

  function automatic logic [31:0] exp_ld(input logic [1:0] sz, input logic [1:0] a, input bit big,
                                         input bit uns, input logic [31:0] rd);
    logic [31:0] v = '0;
    int n = nbytes(sz);
    for (int k = 0; k < n; k++) begin
      logic [7:0] b = rd[8*lane_of(int'(a) + k, big) +: 8];
      if (big) v[8*(n-1-k) +: 8] = b;
      else     v[8*k +: 8] = b;
    end
    if (n == 1 && !uns && v[7])  v[31:8]  = '1;
    if (n == 2 && !uns && v[15]) v[31:16] = '1;
    return v;
  endfunction

  task automatic run_req(input logic [31:0] b, input logic [15:0] off, input logic [1:0] sz,
                         input bit uns, input bit st, input bit big, input logic [31:0] wd,
                         input logic [31:0] rd);
    logic [31:0] ea;
    bit f;
    @(negedge clk);
    req_valid_i = 1'b1; base_i = b; offset_i = off; size_i = sz; unsigned_i = uns;
    store_i = st; big_endian_i = big; wdata_i = wd; rdata_i = $urandom;
    ea = b + {{16{off[15]}}, off};
    f = is_fault(sz, ea);
    #5;
    check(addr_o == ea, "R1 addr", addr_o, ea);
    check(fault_o == f, "R2 fault", 32'(fault_o), 32'(f));
    check(exc_code_o == (f ? (st ? 5'd5 : 5'd4) : 5'd0), "R3 code", 32'(exc_code_o),
          f ? (st ? 32'd5 : 32'd4) : 32'd0);
    check(bad_addr_o == (f ? ea : 32'd0), "R3 bad_addr", bad_addr_o, f ? ea : 32'd0);
    check(mem_req_o == !f, "R4 mem_req", 32'(mem_req_o), 32'(!f));
    if (f) check(be_o == 4'd0, "R4 be on fault", 32'(be_o), 32'd0);
    else if (big) check(be_o == exp_be(sz, ea[1:0], 1'b1), "R7 be", 32'(be_o),
                        32'(exp_be(sz, ea[1:0], 1'b1)));
    else check(be_o == exp_be(sz, ea[1:0], 1'b0), "R6 be", 32'(be_o),
               32'(exp_be(sz, ea[1:0], 1'b0)));
    if (st) check(wdata_o == exp_wd(sz, wd), "R5 wdata", wdata_o, exp_wd(sz, wd));
    @(negedge clk);
    req_valid_i = 1'b0; base_i = $urandom; size_i = 2'($urandom); big_endian_i = ~big;
    unsigned_i = ~uns; rdata_i = rd;
    #5;
    if (!st && !f) begin
      check(load_valid_o == 1'b1, "R8 load_valid", 32'(load_valid_o), 32'd1);
      check(load_data_o == exp_ld(sz, ea[1:0], big, uns, rd), "R9 R10 load_data", load_data_o,
            exp_ld(sz, ea[1:0], big, uns, rd));
    end else begin
      check(load_valid_o == 1'b0, "R8 no load_valid", 32'(load_valid_o), 32'd0);
      check(load_data_o == 32'd0, "R8 load_data idle", load_data_o, 32'd0);
    end
  endtask

  initial begin : watchdog
    #(20 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    #15;
    check(load_valid_o == 1'b0 && be_o == 4'd0 && !fault_o && load_data_o == 0,
          "R4 R8 reset", {be_o, load_valid_o, fault_o}, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    // directed corners
    run_req(32'h0000_1000, 16'hFFFC, 2'd2, 0, 0, 0, 32'h0, 32'h8899_AABB);     // R1 negative offset
    run_req(32'hFFFF_FFFC, 16'h0004, 2'd2, 0, 1, 1, 32'hDEAD_BEEF, 32'h0);     // R1 wrap
    run_req(32'h0000_0101, 16'h0000, 2'd1, 0, 0, 0, 32'h0, 32'h0);             // R3 load fault
    run_req(32'h0000_0102, 16'h0000, 2'd2, 0, 1, 0, 32'h1234_5678, 32'h0);     // R3 store fault
    run_req(32'h0000_0003, 16'h0000, 2'd3, 0, 0, 1, 32'h0, 32'h0);             // R2 reserved size
    run_req(32'h0000_0003, 16'h0000, 2'd0, 0, 0, 1, 32'h0, 32'h80FF_7F01);     // R7 R9 BE byte 3
    run_req(32'h0000_0000, 16'h0000, 2'd0, 0, 0, 1, 32'h0, 32'h80FF_7F01);     // R7 R9 BE byte 0
    run_req(32'h0000_0002, 16'h0000, 2'd1, 1, 0, 0, 32'h0, 32'h8001_7F02);     // R6 R9 LE half
    run_req(32'h0000_0002, 16'h0000, 2'd1, 0, 0, 0, 32'h0, 32'h8001_7F02);     // R9 sign half
    run_req(32'h0000_0001, 16'h0000, 2'd0, 0, 1, 0, 32'h0000_00A5, 32'h0);     // R5 byte replicate
    run_req(32'h0000_0000, 16'h0000, 2'd1, 0, 1, 1, 32'hFFFF_C3D4, 32'h0);     // R5 R7 half
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] b = $urandom;
      if ($urandom % 3 == 0) b[1:0] = 2'b00;
      run_req(b, 16'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              $urandom, $urandom);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule